// File: doc/BRIEF.md
# Register-Controlled Shifter with Carry

This block shifts a 32-bit operand by a count held in a register and produces both the shifted word and the carry-out of the shift. Four kinds of shift are supported: logical left, logical right, arithmetic right and rotate right. It is purely combinational and is meant to sit in the execute stage of a processor datapath, between the register read ports and the flag-update logic.

The count comes from the least significant byte of the amount input. Counts of 32 and above follow the rules below for each shift kind. A rotate uses the count modulo the word width. A count of zero passes the operand through and leaves the carry as it was. A carry write enable tells the flag logic whether the carry output is a newly produced value or only the incoming carry passed back.

Top module: `regshift_carry`

## Requirements
- R1: Only bits [7:0] of `amount_i` form the shift count; bits [31:8] have no effect on any output.
- R2: With a count of zero, `result_o` equals `operand_i` and `carry_o` equals `carry_i`, for every shift kind.
- R3: `carry_we_o` is 1 exactly when the count is nonzero; when it is 0, `carry_o` equals `carry_i`.
- R4: Logical left (kind 2'b00) by n in 1..31 gives `operand_i << n`, with carry equal to operand bit 32-n.
- R5: Logical left by exactly 32 gives result 0 and carry equal to operand bit 0; by more than 32 it gives result 0 and carry 0.
- R6: Logical right (kind 2'b01) by n in 1..31 gives `operand_i >> n`, zero-filled, with carry equal to operand bit n-1.
- R7: Logical right by exactly 32 gives result 0 and carry equal to operand bit 31; by more than 32 it gives result 0 and carry 0.
- R8: Arithmetic right (kind 2'b10) by n in 1..31 fills the vacated bits with operand bit 31, with carry equal to operand bit n-1.
- R9: Arithmetic right by 32 or more gives operand bit 31 copied into every result bit, and carry equal to operand bit 31.
- R10: Rotate right (kind 2'b11) with m = count mod 32 nonzero rotates the operand right by m, with carry equal to operand bit m-1.
- R11: Rotate right with a nonzero count that is a multiple of 32 (32, 64, 96, ...) returns the operand unchanged, with carry equal to operand bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Word to be shifted |
| amount_i | input | 32 | Shift amount register value; only bits [7:0] are used |
| kind_i | input | 2 | Shift kind: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Carry after the shift |
| carry_we_o | output | 1 | High when `carry_o` is a newly produced carry |

## Verification
The block holds no state, so a fault in the count decoder, the barrel stages or the carry index shows on the outputs in the same evaluation as the stimulus that reaches it. A mis-decoded count shows up first at the boundaries 0, 31, 32, 33 and 255, and at rotate counts that are multiples of 32. At those counts the result, the carry or the write enable takes a different branch. A wrong carry index shows up as a single carry bit that disagrees only for operands whose neighbouring bits differ. For that reason the stimulus uses operands with alternating and isolated bits.

// File: rtl/regshift_pkg.sv
package regshift_pkg;

    localparam int unsigned RS_DATA_W   = 32;
    localparam int unsigned RS_CNT_W    = 8;
    localparam int unsigned RS_AMT_IN_W = 32;
    localparam int unsigned RS_SEL_W    = $clog2(RS_DATA_W);

    typedef enum logic [1:0] {
        SK_LSL = 2'd0,
        SK_LSR = 2'd1,
        SK_ASR = 2'd2,
        SK_ROR = 2'd3
    } shift_kind_e;

    // Classification of the shift count byte
    typedef struct packed {
        logic                zero;   // count == 0
        logic                full;   // count == data width
        logic                over;   // count >  data width
        logic [RS_SEL_W-1:0] low;    // count modulo data width
    } cnt_class_t;

    typedef struct packed {
        logic [RS_DATA_W-1:0] data;
        logic                 carry;
        logic                 carry_we;
    } shift_out_t;

endpackage

// File: rtl/shf_cnt_decode.sv
module shf_cnt_decode
    import regshift_pkg::*;
#(
    parameter int unsigned CNT_W  = RS_CNT_W,
    parameter int unsigned DATA_W = RS_DATA_W,
    parameter int unsigned SEL_W  = $clog2(DATA_W)
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic             zero_o,
    output logic             full_o,
    output logic             over_o,
    output logic [SEL_W-1:0] low_o
);
    localparam logic [CNT_W:0] WIDTH_V = (CNT_W+1)'(DATA_W);

    logic [CNT_W:0] cnt_ext;

    always_comb begin
        cnt_ext = {1'b0, cnt_i};
        zero_o  = (cnt_i == '0);
        full_o  = (cnt_ext == WIDTH_V);
        over_o  = (cnt_ext > WIDTH_V);
        low_o   = cnt_i[SEL_W-1:0];
    end

    always_comb begin
        // R3
        cnt_class_excl_chk: assert (!(zero_o && (full_o || over_o)) && !(full_o && over_o));
    end

endmodule

// File: rtl/shf_barrel.sv
module shf_barrel
    import regshift_pkg::*;
#(
    parameter int unsigned DATA_W = RS_DATA_W,
    parameter int unsigned SEL_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din_i,
    input  logic [SEL_W-1:0]  dist_i,
    input  shift_kind_e       kind_i,
    output logic [DATA_W-1:0] dout_o
);
    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] rev_in;
    logic [DATA_W-1:0] rev_out;
    logic [DATA_W-1:0] stage [SEL_W+1];
    logic              is_left;
    logic              is_rot;
    logic              fill_bit;

    assign is_left  = (kind_i == SK_LSL);
    assign is_rot   = (kind_i == SK_ROR);
    assign fill_bit = (kind_i == SK_ASR) ? din_i[DATA_W-1] : 1'b0;

    // A left shift runs through the right-shift network on a bit-reversed word
    for (genvar b = 0; b < DATA_W; b++) begin : g_rev
        assign rev_in[b]  = din_i[DATA_W-1-b];
        assign rev_out[b] = stage[SEL_W][DATA_W-1-b];
    end

    assign src      = is_left ? rev_in : din_i;
    assign stage[0] = src;

    for (genvar s = 0; s < SEL_W; s++) begin : g_stage
        localparam int unsigned D = 1 << s;
        logic [D-1:0] top_bits;
        assign top_bits = is_rot ? stage[s][D-1:0] : {D{fill_bit}};
        assign stage[s+1] = dist_i[s] ? {top_bits, stage[s][DATA_W-1:D]} : stage[s];
    end

    assign dout_o = is_left ? rev_out : stage[SEL_W];

    always_comb begin
        // R8
        asr_sign_keep_chk: assert (kind_i != SK_ASR || dout_o[DATA_W-1] == din_i[DATA_W-1]);
    end

endmodule

// File: rtl/shf_carry_pick.sv
module shf_carry_pick
    import regshift_pkg::*;
#(
    parameter int unsigned DATA_W = RS_DATA_W,
    parameter int unsigned SEL_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din_i,
    input  logic [SEL_W-1:0]  low_i,
    input  shift_kind_e       kind_i,
    output logic              carry_o
);
    // The last bit shifted out. Index arithmetic wraps modulo the data width,
    // so a count of exactly the width picks bit 0 (left) or the top bit (right).
    logic [SEL_W-1:0] idx;

    always_comb begin
        if (kind_i == SK_LSL) begin
            idx = SEL_W'(0) - low_i;
        end else begin
            idx = low_i - SEL_W'(1);
        end
        carry_o = din_i[idx];
    end

endmodule

// File: rtl/regshift_carry.sv
module regshift_carry
    import regshift_pkg::*;
#(
    parameter int unsigned DATA_W   = RS_DATA_W,
    parameter int unsigned AMT_IN_W = RS_AMT_IN_W,
    parameter int unsigned CNT_W    = RS_CNT_W
) (
    input  logic [DATA_W-1:0]   operand_i,
    input  logic [AMT_IN_W-1:0] amount_i,
    input  logic [1:0]          kind_i,
    input  logic                carry_i,
    output logic [DATA_W-1:0]   result_o,
    output logic                carry_o,
    output logic                carry_we_o
);
    localparam int unsigned SEL_W = $clog2(DATA_W);

    shift_kind_e       kind;
    cnt_class_t        cls;
    logic [DATA_W-1:0] shifted;
    logic              picked;
    shift_out_t        res;

    assign kind = shift_kind_e'(kind_i);

    shf_cnt_decode #(.CNT_W(CNT_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_dec (
        .cnt_i  (amount_i[CNT_W-1:0]),
        .zero_o (cls.zero),
        .full_o (cls.full),
        .over_o (cls.over),
        .low_o  (cls.low)
    );

    shf_barrel #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_barrel (
        .din_i  (operand_i),
        .dist_i (cls.low),
        .kind_i (kind),
        .dout_o (shifted)
    );

    shf_carry_pick #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_carry (
        .din_i   (operand_i),
        .low_i   (cls.low),
        .kind_i  (kind),
        .carry_o (picked)
    );

    always_comb begin
        res.data     = operand_i;
        res.carry    = carry_i;
        res.carry_we = 1'b0;
        if (!cls.zero) begin
            res.carry_we = 1'b1;
            unique case (kind)
                SK_LSL, SK_LSR: begin
                    if (cls.over) begin
                        res.data  = '0;
                        res.carry = 1'b0;
                    end else if (cls.full) begin
                        res.data  = '0;
                        res.carry = picked;
                    end else begin
                        res.data  = shifted;
                        res.carry = picked;
                    end
                end
                SK_ASR: begin
                    if (cls.full || cls.over) begin
                        res.data  = {DATA_W{operand_i[DATA_W-1]}};
                        res.carry = operand_i[DATA_W-1];
                    end else begin
                        res.data  = shifted;
                        res.carry = picked;
                    end
                end
                default: begin
                    res.data  = shifted;
                    res.carry = picked;
                end
            endcase
        end
    end

    assign result_o   = res.data;
    assign carry_o    = res.carry;
    assign carry_we_o = res.carry_we;

    always_comb begin
        // R2
        zero_pass_chk: assert (!cls.zero || (result_o == operand_i && carry_o == carry_i));
        // R3
        we_count_chk: assert (carry_we_o == (amount_i[CNT_W-1:0] != '0));
        // R5
        lsl_far_zero_chk: assert (!(kind == SK_LSL && (cls.full || cls.over)) || result_o == '0);
        // R9
        asr_far_fill_chk: assert (!(kind == SK_ASR && (cls.full || cls.over))
                                  || $countones(result_o) == 0 || $countones(result_o) == DATA_W);
        // R10
        ror_bits_kept_chk: assert (kind != SK_ROR || $countones(result_o) == $countones(operand_i));
        // R11
        ror_carry_msb_chk: assert (!(kind == SK_ROR && carry_we_o) || carry_o == result_o[DATA_W-1]);
    end

endmodule

// File: tb/test_regshift_carry.sv
module test_regshift_carry;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] operand;
    logic [31:0] amount;
    logic [1:0]  kind;
    logic        carry_in;
    logic [31:0] result;
    logic        carry_out;
    logic        carry_we;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    regshift_carry i_regshift_carry (
        .operand_i  (operand),
        .amount_i   (amount),
        .kind_i     (kind),
        .carry_i    (carry_in),
        .result_o   (result),
        .carry_o    (carry_out),
        .carry_we_o (carry_we)
    );

    // Expected values written from the requirement list
    task automatic expect_of(input logic [31:0] x, input logic [31:0] amt, input logic [1:0] k,
                             input logic c, output logic [31:0] r, output logic co, output logic we);
        int n;
        int m;
        n = int'(amt[7:0]);
        we = (n != 0);
        r = x; co = c;
        if (n != 0) begin
            case (k)
                2'b00: begin
                    if (n < 32)       begin r = x << n; co = x[32-n]; end
                    else if (n == 32) begin r = 0; co = x[0]; end
                    else              begin r = 0; co = 1'b0; end
                end
                2'b01: begin
                    if (n < 32)       begin r = x >> n; co = x[n-1]; end
                    else if (n == 32) begin r = 0; co = x[31]; end
                    else              begin r = 0; co = 1'b0; end
                end
                2'b10: begin
                    if (n < 32) begin r = 32'($signed(x) >>> n); co = x[n-1]; end
                    else        begin r = {32{x[31]}}; co = x[31]; end
                end
                default: begin
                    m = n % 32;
                    if (m == 0) begin r = x; co = x[31]; end
                    else begin r = (x >> m) | (x << (32 - m)); co = x[m-1]; end
                end
            endcase
        end
    endtask

    task automatic apply(input logic [31:0] x, input logic [31:0] amt, input logic [1:0] k,
                         input logic c);
        @(negedge clk);
        operand = x; amount = amt; kind = k; carry_in = c;
        #5;
    endtask

    task automatic compare(input string tag, input logic [31:0] er, input logic eco, input logic ewe);
        n_checks++;
        if (result !== er || carry_out !== eco || carry_we !== ewe) begin
            n_fail++;
            $display("FAIL %s: op=%h amt=%h kind=%0d cin=%0b got r=%h c=%0b we=%0b expected r=%h c=%0b we=%0b",
                     tag, operand, amount, kind, carry_in, result, carry_out, carry_we, er, eco, ewe);
        end
    endtask

    task automatic run(input string tag, input logic [31:0] x, input logic [31:0] amt,
                       input logic [1:0] k, input logic c);
        logic [31:0] er;
        logic        eco;
        logic        ewe;
        apply(x, amt, k, c);
        expect_of(x, amt, k, c, er, eco, ewe);
        compare(tag, er, eco, ewe);
    endtask

    task automatic t_idle_state;
        // R2 quiet inputs held during reset give a quiet output
        compare("R2 idle", 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_low_byte_only;
        // R1: upper amount bits must not change anything; compare against hand values
        apply(32'h8000_0001, 32'hFFFF_FF00, 2'b00, 1'b1);
        compare("R1 upper-only zero count", 32'h8000_0001, 1'b1, 1'b0);
        apply(32'h8000_0001, 32'h1234_5604, 2'b01, 1'b0);
        compare("R1 upper bits with count 4", 32'h0800_0000, 1'b0, 1'b1);
        run("R1 sweep", 32'hDEAD_BEEF, 32'hA5A5_A521, 2'b10, 1'b0);
    endtask

    task automatic t_zero_count;
        for (int k = 0; k < 4; k++) begin
            run("R2 zero count c=1", 32'hCAFE_F00D, 32'h0, 2'(k), 1'b1);
            run("R3 zero count c=0", 32'h1357_9BDF, 32'h0, 2'(k), 1'b0);
        end
    endtask

    task automatic t_lsl;
        for (int n = 1; n < 32; n++) run("R4 lsl range", 32'hA5C3_0F69 ^ 32'(n), 32'(n), 2'b00, 1'b0);
        apply(32'h0000_0001, 32'd32, 2'b00, 1'b0);
        compare("R5 lsl 32", 32'h0, 1'b1, 1'b1);
        apply(32'hFFFF_FFFF, 32'd33, 2'b00, 1'b1);
        compare("R5 lsl 33", 32'h0, 1'b0, 1'b1);
        run("R5 lsl 255", 32'hFFFF_FFFF, 32'd255, 2'b00, 1'b1);
    endtask

    task automatic t_lsr;
        for (int n = 1; n < 32; n++) run("R6 lsr range", 32'h96F0_3C5A ^ 32'(n << 7), 32'(n), 2'b01, 1'b1);
        apply(32'h8000_0000, 32'd32, 2'b01, 1'b0);
        compare("R7 lsr 32", 32'h0, 1'b1, 1'b1);
        apply(32'hFFFF_FFFF, 32'd64, 2'b01, 1'b1);
        compare("R7 lsr 64", 32'h0, 1'b0, 1'b1);
    endtask

    task automatic t_asr;
        for (int n = 1; n < 32; n++) begin
            run("R8 asr neg", 32'h8421_5AA5 ^ 32'(n), 32'(n), 2'b10, 1'b0);
            run("R8 asr pos", 32'h4210_A55A ^ 32'(n), 32'(n), 2'b10, 1'b1);
        end
        apply(32'h8000_0000, 32'd32, 2'b10, 1'b0);
        compare("R9 asr 32 neg", 32'hFFFF_FFFF, 1'b1, 1'b1);
        apply(32'h7FFF_FFFF, 32'd200, 2'b10, 1'b1);
        compare("R9 asr 200 pos", 32'h0, 1'b0, 1'b1);
    endtask

    task automatic t_ror;
        for (int n = 1; n < 256; n += 5) if (n % 32 != 0)
            run("R10 ror", 32'hB4D2_1E87, 32'(n), 2'b11, 1'b0);
        apply(32'h0000_0003, 32'd1, 2'b11, 1'b0);
        compare("R10 ror 1", 32'h8000_0001, 1'b1, 1'b1);
    endtask

    task automatic t_ror_mult32;
        apply(32'h8000_0000, 32'd32, 2'b11, 1'b0);
        compare("R11 ror 32", 32'h8000_0000, 1'b1, 1'b1);
        apply(32'h7FFF_FFFF, 32'd64, 2'b11, 1'b1);
        compare("R11 ror 64", 32'h7FFF_FFFF, 1'b0, 1'b1);
        run("R11 ror 224", 32'hF0F0_0F0F, 32'd224, 2'b11, 1'b0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        operand = '0; amount = '0; kind = 2'b00; carry_in = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk); #5;
        t_idle_state();
        t_low_byte_only();
        t_zero_count();
        t_lsl();
        t_lsr();
        t_asr();
        t_ror();
        t_ror_mult32();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule